// File: doc/BRIEF.md
# Multi-Region Sector Address Locator

This block turns a byte offset into flash geometry. The flash space is split into up to four erase regions. Each region holds a number of equal sectors, and each region has its own power-of-two sector length. For an offset, the block returns the global sector number, the sector length and the sector's aligned base address. Sector numbers run on from one region into the next, so the first sector of a region is numbered after all the sectors of the regions before it.

Requests arrive one at a time through a valid/ready handshake. After a request is accepted, the block steps through the regions at one region per clock. It keeps a running region base and a running sector count. When it finds the region that holds the offset, it pulses a done strobe together with the result. The block samples the region configuration once, on the first clock after reset. From that point on it refuses every request if the configuration broke a rule.

The configuration can take one of two forms. A per-region list may be given; a block count of zero ends that list. If no list is given, a single uniform region is used instead. Storage access and command decoding are handled by other blocks.

Top module: `sector_locator`

## Requirements
- R1: The per-region list ends at the first region whose block count is zero. The configuration of any later region has no effect on errors or results.
- R2: Sector numbers are cumulative. The first sector of region i is numbered by the sum of the block counts of regions 0 to i-1.
- R3: For an offset in region i, `rsp_sector` equals the start number of region i plus (offset - region base) / sector length. `rsp_len` equals that region's sector length.
- R4: A sector length of an active region must be a power of two, at least 256 (a multiple of 256) and below 2^24. Any other length sets `cfg_error`.
- R5: The base address of each active region must be a multiple of that region's sector length. A misaligned region sets `cfg_error`.
- R6: When region 0 has a block count of zero, one uniform region is used, made of `cfg_uni_blocks` sectors of `cfg_uni_len` bytes. Two cases set `cfg_error`: that uniform count is zero, or the list is present and the uniform product is nonzero but differs from the list's total size.
- R7: `rsp_base` equals the offset with the low log2(sector length) bits cleared.
- R8: An offset at or above the total chip length gets a response with `rsp_err` high. While `cfg_error` is high, every request gets a response with `rsp_err` high. A response with `rsp_err` high reports zero sector, length and base.
- R9: Let c be the cycle in which a request is accepted. `rsp_done` is high for one cycle: in cycle c+1 for a rejected request, and in cycle c+2+i for a sector found in region i.
- R10: `req_ready` is low during reset and low while a request is being resolved. It is high in the cycle in which `rsp_done` is high. `cfg_error` holds the configuration verdict from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_blocks | input | NREG x CNT_W | Block count of each listed region (0 ends the list) |
| cfg_sect_len | input | NREG x LEN_W | Sector length in bytes of each listed region |
| cfg_uni_blocks | input | CNT_W | Block count of the uniform form |
| cfg_uni_len | input | LEN_W | Sector length of the uniform form |
| req_valid | input | 1 | Request strobe |
| req_offset | input | ADDR_W | Byte offset to locate |
| req_ready | output | 1 | Block can accept a request |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is a rejection |
| rsp_sector | output | SEC_W | Global sector number |
| rsp_len | output | LEN_W | Sector length in bytes |
| rsp_base | output | ADDR_W | Aligned sector base address |
| cfg_error | output | 1 | Configuration sampled after reset is invalid |

## Verification
If the running sector count goes wrong, every sector number from the following region onward shifts by a fixed amount, and this shows on the first response for that region. If the running base goes wrong, either a region boundary moves or an offset is wrongly rejected. Either fault shows at the edges of each region, which the vectors probe on both sides. A region index stuck at one value, or one that skips a region, shifts the done strobe away from the cycle given by R9, so the latency checks catch it within a few cycles. A wrong configuration verdict shows on the very next request, as a rejection where none should occur or as a result where a rejection is due.

// File: rtl/sector_locator_pkg.sv
package sector_locator_pkg;

   typedef enum logic [0:0] {
      WALK_IDLE = 1'b0,
      WALK_SCAN = 1'b1
   } walk_state_t;

   // Index of the highest set bit (0 when the vector is zero).
   function automatic int top_bit(input logic [63:0] v);
      int pos;
      pos = 0;
      for (int k = 0; k < 64; k++) begin
         if (v[k]) pos = k;
      end
      return pos;
   endfunction

endpackage

// File: rtl/slc_cfg_check.sv
module slc_cfg_check
   import sector_locator_pkg::*;
#(
   parameter int NREG   = 4,
   parameter int CNT_W  = 12,
   parameter int LEN_W  = 25,
   parameter int SIZE_W = 39,
   parameter int LOG_W  = 5
) (
   input  logic [NREG-1:0][CNT_W-1:0] reg_cnt_i,
   input  logic [NREG-1:0][LEN_W-1:0] reg_len_i,
   input  logic [CNT_W-1:0]           uni_cnt_i,
   input  logic [LEN_W-1:0]           uni_len_i,
   output logic [CNT_W-1:0]           eff_cnt_o  [NREG],
   output logic [LOG_W-1:0]           eff_log_o  [NREG],
   output logic [SIZE_W-1:0]          eff_size_o [NREG],
   output logic [SIZE_W-1:0]          total_o,
   output logic                       bad_o
);

   localparam logic [63:0] LEN_CEIL = 64'h0000_0000_0100_0000;

   logic                list_mode;
   logic [NREG-1:0]     alive;
   logic [NREG-1:0]     reg_bad;
   logic [SIZE_W-1:0]   run_base [NREG+1];
   logic [SIZE_W-1:0]   uni_size;

   assign list_mode   = (reg_cnt_i[0] != '0);
   assign run_base[0] = '0;
   assign uni_size    = SIZE_W'(uni_cnt_i) * SIZE_W'(uni_len_i);

   for (genvar g = 0; g < NREG; g++) begin : g_region
      logic [CNT_W-1:0]  cnt_sel;
      logic [LEN_W-1:0]  len_sel;
      logic              active;
      logic              len_ok;
      logic              aligned;
      logic [SIZE_W-1:0] len_mask;

      if (g == 0) begin : g_first
         assign cnt_sel = list_mode ? reg_cnt_i[0] : uni_cnt_i;
         assign len_sel = list_mode ? reg_len_i[0] : uni_len_i;
         assign alive[0] = (cnt_sel != '0);
      end else begin : g_rest
         assign cnt_sel = list_mode ? reg_cnt_i[g] : '0;
         assign len_sel = list_mode ? reg_len_i[g] : '0;
         assign alive[g] = alive[g-1] && (cnt_sel != '0);
      end

      assign active   = alive[g];
      assign len_ok   = $onehot(len_sel) && (len_sel[7:0] == 8'h00) &&
                        (64'(len_sel) < LEN_CEIL);
      assign len_mask = SIZE_W'(len_sel) - SIZE_W'(1);
      assign aligned  = ((run_base[g] & len_mask) == '0);

      assign eff_cnt_o[g]  = active ? cnt_sel : '0;
      assign eff_log_o[g]  = LOG_W'(top_bit(64'(len_sel)));
      assign eff_size_o[g] = active ? (SIZE_W'(cnt_sel) * SIZE_W'(len_sel)) : '0;
      assign run_base[g+1] = run_base[g] + eff_size_o[g];
      assign reg_bad[g]    = active && !(len_ok && aligned);
   end

   assign total_o = run_base[NREG];

   always_comb begin
      bad_o = |reg_bad;
      if (!list_mode && (uni_cnt_i == '0)) bad_o = 1'b1;
      if (list_mode && (uni_size != '0) && (uni_size != total_o)) bad_o = 1'b1;
   end

endmodule

// File: rtl/slc_walker.sv
module slc_walker
   import sector_locator_pkg::*;
#(
   parameter int NREG   = 4,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 12,
   parameter int LEN_W  = 25,
   parameter int SIZE_W = 39,
   parameter int LOG_W  = 5,
   parameter int SEC_W  = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_bad_i,
   input  logic [SIZE_W-1:0]   total_i,
   input  logic [CNT_W-1:0]    cnt_i  [NREG],
   input  logic [LOG_W-1:0]    log_i  [NREG],
   input  logic [SIZE_W-1:0]   size_i [NREG],
   input  logic                req_valid_i,
   input  logic [ADDR_W-1:0]   req_offset_i,
   output logic                req_ready_o,
   output logic                done_o,
   output logic                err_o,
   output logic [SEC_W-1:0]    sector_o,
   output logic [LEN_W-1:0]    len_o,
   output logic [ADDR_W-1:0]   base_o,
   output logic                cfg_err_o
);

   localparam int RI_W = (NREG > 1) ? $clog2(NREG) : 1;

   walk_state_t       state_q;
   logic              checked_q;
   logic              bad_q;
   logic [RI_W-1:0]   ridx_q;
   logic [SIZE_W-1:0] rbase_q;
   logic [SEC_W-1:0]  rstart_q;
   logic [ADDR_W-1:0] off_q;

   logic [SIZE_W-1:0] off_ext;
   logic [SIZE_W-1:0] req_ext;
   logic [SIZE_W-1:0] reg_end;
   logic [LOG_W-1:0]  cur_log;
   logic [SIZE_W-1:0] rel_off;
   logic [ADDR_W-1:0] low_mask;

   assign off_ext  = SIZE_W'(off_q);
   assign req_ext  = SIZE_W'(req_offset_i);
   assign cur_log  = log_i[ridx_q];
   assign reg_end  = rbase_q + size_i[ridx_q];
   assign rel_off  = (off_ext - rbase_q) >> cur_log;
   assign low_mask = (ADDR_W'(1) << cur_log) - ADDR_W'(1);

   assign req_ready_o = (state_q == WALK_IDLE) && checked_q;
   assign cfg_err_o   = bad_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= WALK_IDLE;
         checked_q <= 1'b0;
         bad_q     <= 1'b0;
         ridx_q    <= '0;
         rbase_q   <= '0;
         rstart_q  <= '0;
         off_q     <= '0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
         sector_o  <= '0;
         len_o     <= '0;
         base_o    <= '0;
      end else begin
         done_o <= 1'b0;
         if (!checked_q) begin
            checked_q <= 1'b1;
            bad_q     <= cfg_bad_i;
         end
         case (state_q)
            WALK_IDLE: begin
               if (req_valid_i && checked_q) begin
                  if (bad_q || (req_ext >= total_i)) begin
                     done_o   <= 1'b1;
                     err_o    <= 1'b1;
                     sector_o <= '0;
                     len_o    <= '0;
                     base_o   <= '0;
                  end else begin
                     state_q  <= WALK_SCAN;
                     off_q    <= req_offset_i;
                     ridx_q   <= '0;
                     rbase_q  <= '0;
                     rstart_q <= '0;
                  end
               end
            end
            WALK_SCAN: begin
               if (off_ext < reg_end) begin
                  done_o   <= 1'b1;
                  err_o    <= 1'b0;
                  sector_o <= rstart_q + SEC_W'(rel_off);
                  len_o    <= LEN_W'(1) << cur_log;
                  base_o   <= off_q & ~low_mask;
                  state_q  <= WALK_IDLE;
               end else begin
                  rbase_q  <= reg_end;
                  rstart_q <= rstart_q + SEC_W'(cnt_i[ridx_q]);
                  ridx_q   <= ridx_q + RI_W'(1);
               end
            end
            default: state_q <= WALK_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sector_locator.sv
module sector_locator
   import sector_locator_pkg::*;
#(
   parameter int NREG   = 4,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 12,
   parameter int LEN_W  = 25,
   parameter int SEC_W  = CNT_W + 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NREG-1:0][CNT_W-1:0] cfg_blocks,
   input  logic [NREG-1:0][LEN_W-1:0] cfg_sect_len,
   input  logic [CNT_W-1:0]           cfg_uni_blocks,
   input  logic [LEN_W-1:0]           cfg_uni_len,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_offset,
   output logic                       req_ready,
   output logic                       rsp_done,
   output logic                       rsp_err,
   output logic [SEC_W-1:0]           rsp_sector,
   output logic [LEN_W-1:0]           rsp_len,
   output logic [ADDR_W-1:0]          rsp_base,
   output logic                       cfg_error
);

   localparam int SIZE_W = CNT_W + LEN_W + 2;
   localparam int LOG_W  = $clog2(LEN_W);

   if (NREG < 1 || NREG > 4) begin : g_bad_nreg
      $error("sector_locator: NREG must be 1..4");
   end
   if (LEN_W < 9 || LEN_W > 64) begin : g_bad_len
      $error("sector_locator: LEN_W must be 9..64");
   end
   if (SIZE_W < ADDR_W) begin : g_bad_addr
      $error("sector_locator: ADDR_W wider than region size arithmetic");
   end

   logic [CNT_W-1:0]  eff_cnt  [NREG];
   logic [LOG_W-1:0]  eff_log  [NREG];
   logic [SIZE_W-1:0] eff_size [NREG];
   logic [SIZE_W-1:0] total;
   logic              cfg_bad;

   slc_cfg_check #(
      .NREG(NREG), .CNT_W(CNT_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .LOG_W(LOG_W)
   ) u_cfg (
      .reg_cnt_i  (cfg_blocks),
      .reg_len_i  (cfg_sect_len),
      .uni_cnt_i  (cfg_uni_blocks),
      .uni_len_i  (cfg_uni_len),
      .eff_cnt_o  (eff_cnt),
      .eff_log_o  (eff_log),
      .eff_size_o (eff_size),
      .total_o    (total),
      .bad_o      (cfg_bad)
   );

   slc_walker #(
      .NREG(NREG), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
      .SIZE_W(SIZE_W), .LOG_W(LOG_W), .SEC_W(SEC_W)
   ) u_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_bad_i    (cfg_bad),
      .total_i      (total),
      .cnt_i        (eff_cnt),
      .log_i        (eff_log),
      .size_i       (eff_size),
      .req_valid_i  (req_valid),
      .req_offset_i (req_offset),
      .req_ready_o  (req_ready),
      .done_o       (rsp_done),
      .err_o        (rsp_err),
      .sector_o     (rsp_sector),
      .len_o        (rsp_len),
      .base_o       (rsp_base),
      .cfg_err_o    (cfg_error)
   );

endmodule

// File: rtl/sector_locator_chk.sv
module sector_locator_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 25,
   parameter int SEC_W  = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_done,
   input logic              rsp_err,
   input logic [SEC_W-1:0]  rsp_sector,
   input logic [LEN_W-1:0]  rsp_len,
   input logic [ADDR_W-1:0] rsp_base,
   input logic              cfg_error
);

   // R4
   len_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !rsp_err) |-> ($onehot(rsp_len) && (rsp_len[7:0] == 8'h00)));

   // R7
   base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !rsp_err) |-> ((ADDR_W'(rsp_base) & ADDR_W'(rsp_len - LEN_W'(1))) == '0));

   // R8
   cfg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && cfg_error) |-> rsp_err);

   // R8
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_err) |-> (rsp_sector == '0 && rsp_len == '0 && rsp_base == '0));

   // R10
   ready_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);

endmodule

bind sector_locator sector_locator_chk #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEC_W(SEC_W)
) u_sector_locator_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_done   (rsp_done),
   .rsp_err    (rsp_err),
   .rsp_sector (rsp_sector),
   .rsp_len    (rsp_len),
   .rsp_base   (rsp_base),
   .cfg_error  (cfg_error)
);

// File: tb/test_sector_locator.sv
module test_sector_locator;

   localparam int NREG   = 4;
   localparam int ADDR_W = 32;
   localparam int CNT_W  = 12;
   localparam int LEN_W  = 25;
   localparam int SEC_W  = CNT_W + 2;

   typedef struct packed {
      logic [31:0] off;
      logic [13:0] idx;
      logic [24:0] len;
      logic [31:0] base;
      logic        err;
      logic [3:0]  lat;
   } vec_t;

   // Config A: r0 8 x 0x2000, r1 4 x 0x10000, r2 2 x 0x100, total 0x50200
   localparam vec_t VECS [10] = '{
      '{32'h0000_0000, 14'd0,  25'h2000,  32'h0000_0000, 1'b0, 4'd2},
      '{32'h0000_3FFF, 14'd1,  25'h2000,  32'h0000_2000, 1'b0, 4'd2},
      '{32'h0000_FFFF, 14'd7,  25'h2000,  32'h0000_E000, 1'b0, 4'd2},
      '{32'h0001_0000, 14'd8,  25'h10000, 32'h0001_0000, 1'b0, 4'd3},
      '{32'h0004_FFFF, 14'd11, 25'h10000, 32'h0004_0000, 1'b0, 4'd3},
      '{32'h0002_1234, 14'd9,  25'h10000, 32'h0002_0000, 1'b0, 4'd3},
      '{32'h0005_0000, 14'd12, 25'h100,   32'h0005_0000, 1'b0, 4'd4},
      '{32'h0005_01FF, 14'd13, 25'h100,   32'h0005_0100, 1'b0, 4'd4},
      '{32'h0005_0200, 14'd0,  25'h0,     32'h0,         1'b1, 4'd1},
      '{32'hFFFF_FFFF, 14'd0,  25'h0,     32'h0,         1'b1, 4'd1}
   };

   logic                       clk = 1'b0;
   logic                       rst_n = 1'b0;
   logic [NREG-1:0][CNT_W-1:0] cfg_blocks = '0;
   logic [NREG-1:0][LEN_W-1:0] cfg_sect_len = '0;
   logic [CNT_W-1:0]           cfg_uni_blocks = '0;
   logic [LEN_W-1:0]           cfg_uni_len = '0;
   logic                       req_valid = 1'b0;
   logic [ADDR_W-1:0]          req_offset = '0;
   logic                       req_ready;
   logic                       rsp_done;
   logic                       rsp_err;
   logic [SEC_W-1:0]           rsp_sector;
   logic [LEN_W-1:0]           rsp_len;
   logic [ADDR_W-1:0]          rsp_base;
   logic                       cfg_error;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sector_locator #(
      .NREG(NREG), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
   ) i_sector_locator (
      .clk(clk), .rst_n(rst_n),
      .cfg_blocks(cfg_blocks), .cfg_sect_len(cfg_sect_len),
      .cfg_uni_blocks(cfg_uni_blocks), .cfg_uni_len(cfg_uni_len),
      .req_valid(req_valid), .req_offset(req_offset),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err),
      .rsp_sector(rsp_sector), .rsp_len(rsp_len), .rsp_base(rsp_base),
      .cfg_error(cfg_error)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Starts and ends at a falling edge; lat counts cycles after acceptance.
   task automatic issue(input logic [31:0] off, output int lat, output logic saw_busy);
      req_offset = off;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      saw_busy = !req_ready;
      while (!rsp_done && lat < 20) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic cfg_list_a();
      cfg_blocks   = '0;
      cfg_sect_len = '0;
      cfg_blocks[0] = 12'd8; cfg_sect_len[0] = 25'h2000;
      cfg_blocks[1] = 12'd4; cfg_sect_len[1] = 25'h10000;
      cfg_blocks[2] = 12'd2; cfg_sect_len[2] = 25'h100;
      cfg_uni_blocks = '0;
      cfg_uni_len    = '0;
   endtask

   initial begin
      int lat;
      logic busy;
      // R10: reset state
      @(negedge clk);
      check("R10 ready in reset", 64'(req_ready), 64'd0);
      check("R9 done in reset", 64'(rsp_done), 64'd0);

      cfg_list_a();
      do_reset();
      check("R10 ready after reset", 64'(req_ready), 64'd1);
      check("R4 cfg A valid", 64'(cfg_error), 64'd0);

      foreach (VECS[k]) begin
         issue(VECS[k].off, lat, busy);
         check("R9 latency", 64'(lat), 64'(VECS[k].lat));
         check("R8 err", 64'(rsp_err), 64'(VECS[k].err));
         check("R2 R3 sector", 64'(rsp_sector), 64'(VECS[k].idx));
         check("R3 length", 64'(rsp_len), 64'(VECS[k].len));
         check("R7 base", 64'(rsp_base), 64'(VECS[k].base));
         if (VECS[k].lat > 1) check("R10 busy while walking", 64'(busy), 64'd1);
         @(negedge clk);
         check("R9 done one cycle", 64'(rsp_done), 64'd0);
      end

      // R1: list ends at region 1; region 2 holds an illegal length
      cfg_list_a();
      cfg_blocks[1] = 12'd0;
      cfg_blocks[2] = 12'd3; cfg_sect_len[2] = 25'h300;
      do_reset();
      check("R1 later region ignored", 64'(cfg_error), 64'd0);
      issue(32'h0001_0000, lat, busy);
      check("R1 end of list rejects", 64'(rsp_err), 64'd1);
      issue(32'h0000_C000, lat, busy);
      check("R1 first region still works", 64'(rsp_sector), 64'd6);

      // R4: not a power of two
      cfg_list_a(); cfg_sect_len[0] = 25'h300;
      do_reset();
      check("R4 len 0x300", 64'(cfg_error), 64'd1);
      issue(32'h0, lat, busy);
      check("R8 cfg error rejects", 64'(rsp_err), 64'd1);
      check("R9 cfg reject latency", 64'(lat), 64'd1);

      // R4: below 256
      cfg_list_a(); cfg_sect_len[2] = 25'h80;
      do_reset();
      check("R4 len 0x80", 64'(cfg_error), 64'd1);

      // R4: 2^24 too large
      cfg_list_a(); cfg_sect_len[1] = 25'h100_0000;
      do_reset();
      check("R4 len 2^24", 64'(cfg_error), 64'd1);

      // R5: region 1 base 0x300 not aligned to 0x1000
      cfg_blocks = '0; cfg_sect_len = '0;
      cfg_blocks[0] = 12'd3; cfg_sect_len[0] = 25'h100;
      cfg_blocks[1] = 12'd1; cfg_sect_len[1] = 25'h1000;
      do_reset();
      check("R5 misaligned region", 64'(cfg_error), 64'd1);

      // R6: uniform form
      cfg_blocks = '0; cfg_sect_len = '0;
      cfg_sect_len[1] = 25'h7;
      cfg_uni_blocks = 12'd16; cfg_uni_len = 25'h1000;
      do_reset();
      check("R6 uniform valid", 64'(cfg_error), 64'd0);
      issue(32'h0000_5678, lat, busy);
      check("R6 uniform sector", 64'(rsp_sector), 64'd5);
      check("R6 uniform base", 64'(rsp_base), 64'h5000);
      check("R6 uniform len", 64'(rsp_len), 64'h1000);
      issue(32'h0001_0000, lat, busy);
      check("R6 uniform end", 64'(rsp_err), 64'd1);

      // R6: no form given
      cfg_uni_blocks = '0;
      do_reset();
      check("R6 nothing given", 64'(cfg_error), 64'd1);

      // R6: both forms with matching size
      cfg_list_a(); cfg_uni_blocks = 12'h502; cfg_uni_len = 25'h100;
      do_reset();
      check("R6 both match", 64'(cfg_error), 64'd0);

      // R6: both forms with mismatched size
      cfg_uni_blocks = 12'h503;
      do_reset();
      check("R6 both mismatch", 64'(cfg_error), 64'd1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule